// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block sits beside a processor's coprocessor-transfer path. Each access presents a 32-bit transfer instruction word together with a read strobe or a write strobe, plus write data for writes. The block picks the instruction apart into its major register, minor register and two opcode fields. It then selects one of a small set of stored control registers: the process identifier, the context identifier, three thread-identifier words, two translation-table bases, a translation mask, an implementation access word and, in protection-unit builds, a bank of region descriptors.

Results are registered and appear one clock after the strobe: read data with a valid flag, or an illegal-access flag for any encoding the block does not implement. Some writes change state that a cache or translation unit depends on. These writes raise single-cycle request pulses, but only when the stored value actually changes. A read of the cache-maintenance register returns zero and pulses a request to clear the processor's condition flags. The block drives no cache or translation logic itself. It only emits these requests.

Top module: `sysctl_regfile`

## Requirements
- R1: Fields are taken from fixed bit positions of `insn`: opcode-1 in bits 23:21, major register in bits 19:16, opcode-2 in bits 7:5 and minor register in bits 3:0. Opcode-1 and every other bit have no effect on selection.
- R2: A legal write to major 13, opcode-2 0 (process identifier) with data that differs from the stored word pulses `tlb_flush_all` for one cycle. A write of equal data gives no pulse. Either way the register then holds the data.
- R3: A legal write to major 13, opcode-2 1 (context identifier) with changed data pulses `tlb_flush_asid`. There is no pulse for unchanged data, and never any pulse when `PU_MODE` is nonzero.
- R4: Major 13 with opcode-2 2, 3 and 4 selects three independent 32-bit thread words. Opcode-2 5 to 7 under major 13 are illegal.
- R5: A read of major 2, opcode-2 2 returns the number of single-bit left shifts that bring the stored mask to zero. This is 32 minus the index of its lowest set bit, or 0 for a zero mask. A write to the same encoding stores the mask.
- R6: Major 2 with opcode-2 0 and 1 are two 32-bit translation-base registers that read back what was written. Other opcode-2 values under major 2 are illegal.
- R7: With `PU_MODE` nonzero, major 6 selects one of `NUM_REGIONS` (8) region words by the minor field, and a minor value of 8 or more is illegal. With `PU_MODE` zero, every major-6 access is illegal.
- R8: Major 15, opcode-2 0, minor 1 is the access word. It keeps only bits 13:0 and reads back zero-extended. A write that changes those 14 bits pulses `tc_flush`. Every other major-15 encoding is illegal.
- R9: Majors 0, 1, 3, 4, 5, 8, 9, 10, 11, 12 and 14 are illegal for both reads and writes. An illegal access raises `illegal` and changes no stored register.
- R10: A read of major 7 returns zero with `rd_valid` and pulses `clr_flags`. A write to major 7 is accepted and has no visible effect.
- R11: Outputs are registered and reflect the strobe of the previous cycle. `rd_valid` is high only for a legal read. When `rd_en` and `wr_en` are both high, the access is a write and no read data is returned.
- R12: Reset (active low) clears every stored register to zero. All outputs are zero in the cycle after reset and in any cycle after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn | input | 32 | Transfer instruction word |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (wins over read) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, zero unless a legal read |
| rd_valid | output | 1 | Legal read completed last cycle |
| illegal | output | 1 | Access last cycle hit an unimplemented encoding |
| tlb_flush_all | output | 1 | Full translation flush request pulse |
| tlb_flush_asid | output | 1 | Non-global translation flush request pulse |
| tc_flush | output | 1 | Translation-cache flush request pulse |
| clr_flags | output | 1 | Clear condition flags request pulse |

## Verification
A corrupted stored word only shows at the ports when that register is read back, or when a later write compares against it. The bench therefore follows each write with a read, or with a repeat write that must stay silent, within a few cycles. A decode slip appears on the very next cycle as a wrong `illegal`, a missing `rd_valid` or data from a neighbouring register. The mask count is checked at its extremes (lowest and highest bit, and zero) and at one interior value, so an off-by-one in the count shows as a wrong read value. Both build modes run side by side on identical stimulus, so any leak of the protection-unit setting into the other variant appears in the same cycle.

// File: rtl/sysctl_pkg.sv
// Shared types for the system control register file.
// Assumes the fixed 32-bit transfer instruction layout; field positions are behaviour.
package sysctl_pkg;

    // Which storage element an access targets.
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PID,
        SEL_CTX,
        SEL_THR,
        SEL_BASE0,
        SEL_BASE1,
        SEL_MASK,
        SEL_REGION,
        SEL_ACC,
        SEL_CACHE
    } sel_e;

    // Decoded instruction fields.
    typedef struct packed {
        logic [2:0] op1;
        logic [3:0] major;
        logic [2:0] op2;
        logic [3:0] minor;
    } fields_t;

    // Extract the fields from their fixed positions.
    function automatic fields_t split_insn(input logic [31:0] w);
        fields_t f;
        f.op1   = w[23:21];
        f.major = w[19:16];
        f.op2   = w[7:5];
        f.minor = w[3:0];
        return f;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Maps major/op2/minor fields to a storage select and index.
// Assumes PU_MODE and the register counts are fixed at build time.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int PU_MODE     = 0,
    parameter int NUM_THREAD  = 3,
    parameter int NUM_REGIONS = 8
) (
    input  logic [3:0] major,
    input  logic [2:0] op2,
    input  logic [3:0] minor,
    output sel_e       sel,
    output logic [3:0] idx,
    output logic       legal
);

    localparam int THR_FIRST = 2;

    // Select the target register from the encoding.
    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        case (major)
            4'd2: begin
                case (op2)
                    3'd0:    sel = SEL_BASE0;
                    3'd1:    sel = SEL_BASE1;
                    3'd2:    sel = SEL_MASK;
                    default: sel = SEL_NONE;
                endcase
            end
            4'd6: begin
                if (PU_MODE != 0 && int'(minor) < NUM_REGIONS) begin
                    sel = SEL_REGION;
                    idx = minor;
                end
            end
            4'd7: sel = SEL_CACHE;
            4'd13: begin
                if (op2 == 3'd0) begin
                    sel = SEL_PID;
                end else if (op2 == 3'd1) begin
                    sel = SEL_CTX;
                end else if (int'(op2) >= THR_FIRST && int'(op2) < THR_FIRST + NUM_THREAD) begin
                    sel = SEL_THR;
                    idx = {1'b0, op2} - 4'(THR_FIRST);
                end
            end
            4'd15: begin
                if (op2 == 3'd0 && minor == 4'd1) sel = SEL_ACC;
            end
            default: sel = SEL_NONE;
        endcase
    end

    assign legal = (sel != SEL_NONE);

endmodule

// File: rtl/sysctl_shcount.sv
// Counts the left shifts needed to clear a mask: width minus lowest set bit index.
// Assumes a zero mask yields zero.
module sysctl_shcount #(
    parameter int DATA_W = 32,
    localparam int CW    = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] mask,
    output logic [CW-1:0]     count
);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        count = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (mask[i]) count = CW'(DATA_W - i);
        end
    end

endmodule

// File: rtl/sysctl_store.sv
// Holds the control registers, forms the read word and the change-detect pulses.
// Assumes wr/rd are already qualified by legality and write priority.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PU_MODE     = 0,
    parameter int NUM_THREAD  = 3,
    parameter int NUM_REGIONS = 8,
    parameter int ACC_BITS    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  sel_e              sel,
    input  logic [3:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic              flush_all,
    output logic              flush_asid,
    output logic              flush_tc,
    output logic              flags_clr
);

    localparam int CW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0]   pid_q, ctx_q, base0_q, base1_q, mask_q;
    logic [ACC_BITS-1:0] acc_q;
    logic [DATA_W-1:0]   thr_q [NUM_THREAD];
    logic [DATA_W-1:0]   reg_q [NUM_REGIONS];
    logic [CW-1:0]       shifts;

    sysctl_shcount #(.DATA_W(DATA_W)) i_shcount (
        .mask  (mask_q),
        .count (shifts)
    );

    // Scalar registers and the one-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_q      <= '0;
            ctx_q      <= '0;
            base0_q    <= '0;
            base1_q    <= '0;
            mask_q     <= '0;
            acc_q      <= '0;
            flush_all  <= 1'b0;
            flush_asid <= 1'b0;
            flush_tc   <= 1'b0;
            flags_clr  <= 1'b0;
        end else begin
            flush_all  <= wr && sel == SEL_PID && wdata != pid_q;
            flush_asid <= (PU_MODE == 0) && wr && sel == SEL_CTX && wdata != ctx_q;
            flush_tc   <= wr && sel == SEL_ACC && wdata[ACC_BITS-1:0] != acc_q;
            flags_clr  <= rd && sel == SEL_CACHE;
            if (wr) begin
                case (sel)
                    SEL_PID:   pid_q   <= wdata;
                    SEL_CTX:   ctx_q   <= wdata;
                    SEL_BASE0: base0_q <= wdata;
                    SEL_BASE1: base1_q <= wdata;
                    SEL_MASK:  mask_q  <= wdata;
                    SEL_ACC:   acc_q   <= wdata[ACC_BITS-1:0];
                    default:   ;
                endcase
            end
        end
    end

    for (genvar t = 0; t < NUM_THREAD; t++) begin : g_thr
        // One thread word, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) thr_q[t] <= '0;
            else if (wr && sel == SEL_THR && idx == 4'(t)) thr_q[t] <= wdata;
        end
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
        // One region word, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) reg_q[r] <= '0;
            else if (wr && sel == SEL_REGION && idx == 4'(r)) reg_q[r] <= wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_PID:   rd_word = pid_q;
            SEL_CTX:   rd_word = ctx_q;
            SEL_BASE0: rd_word = base0_q;
            SEL_BASE1: rd_word = base1_q;
            SEL_MASK:  rd_word = DATA_W'(shifts);
            SEL_ACC:   rd_word = DATA_W'(acc_q);
            SEL_THR: begin
                for (int t = 0; t < NUM_THREAD; t++)
                    if (idx == 4'(t)) rd_word = thr_q[t];
            end
            SEL_REGION: begin
                for (int r = 0; r < NUM_REGIONS; r++)
                    if (idx == 4'(r)) rd_word = reg_q[r];
            end
            default: rd_word = '0;
        endcase
    end

endmodule

// File: rtl/sysctl_regfile.sv
// Top: decodes a transfer instruction, accesses the register store and
// registers the result, legality flag and request pulses one cycle later.
// Assumes at most one access per cycle; write wins if both strobes are high.
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PU_MODE     = 0,
    parameter int NUM_THREAD  = 3,
    parameter int NUM_REGIONS = 8,
    parameter int ACC_BITS    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       insn,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              illegal,
    output logic              tlb_flush_all,
    output logic              tlb_flush_asid,
    output logic              tc_flush,
    output logic              clr_flags
);

    fields_t           fld;
    sel_e              sel;
    logic [3:0]        idx;
    logic              legal;
    logic [DATA_W-1:0] rd_word;
    logic              do_rd;
    logic              unused_insn_bits;

    assign fld              = split_insn(insn);
    assign unused_insn_bits = ^{fld.op1, insn[31:24], insn[20], insn[15:8], insn[4]};
    assign do_rd            = rd_en && !wr_en;

    sysctl_decode #(
        .PU_MODE     (PU_MODE),
        .NUM_THREAD  (NUM_THREAD),
        .NUM_REGIONS (NUM_REGIONS)
    ) i_decode (
        .major (fld.major),
        .op2   (fld.op2),
        .minor (fld.minor),
        .sel   (sel),
        .idx   (idx),
        .legal (legal)
    );

    sysctl_store #(
        .DATA_W      (DATA_W),
        .PU_MODE     (PU_MODE),
        .NUM_THREAD  (NUM_THREAD),
        .NUM_REGIONS (NUM_REGIONS),
        .ACC_BITS    (ACC_BITS)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_en && legal),
        .rd         (do_rd && legal),
        .sel        (sel),
        .idx        (idx),
        .wdata      (wdata),
        .rd_word    (rd_word),
        .flush_all  (tlb_flush_all),
        .flush_asid (tlb_flush_asid),
        .flush_tc   (tc_flush),
        .flags_clr  (clr_flags)
    );

    // Register the read result and the legality flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
            illegal  <= 1'b0;
        end else begin
            rd_valid <= do_rd && legal;
            illegal  <= (rd_en || wr_en) && !legal;
            rdata    <= (do_rd && legal) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/sysctl_regfile_chk.sv
// Port-level temporal checks for sysctl_regfile, attached by bind.
// Assumes synchronous active-low reset.
module sysctl_regfile_chk #(
    parameter int DATA_W  = 32,
    parameter int PU_MODE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_valid,
    input logic              illegal,
    input logic              tlb_flush_all,
    input logic              tlb_flush_asid,
    input logic              tc_flush,
    input logic              clr_flags
);

    // R2
    flush_all_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_all |-> $past(wr_en));

    // R3
    flush_asid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_asid |-> (PU_MODE == 0) && $past(wr_en));

    // R8
    tc_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_flush |-> $past(wr_en));

    // R10
    clr_flags_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flags |-> rd_valid && rdata == '0);

    // R11
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !wr_en));

    // R11
    valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !rd_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en || wr_en) |-> !(rd_valid || illegal || tlb_flush_all ||
            tlb_flush_asid || tc_flush || clr_flags) && rdata == '0);

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.DATA_W(DATA_W), .PU_MODE(PU_MODE)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_en          (rd_en),
    .wr_en          (wr_en),
    .rdata          (rdata),
    .rd_valid       (rd_valid),
    .illegal        (illegal),
    .tlb_flush_all  (tlb_flush_all),
    .tlb_flush_asid (tlb_flush_asid),
    .tc_flush       (tc_flush),
    .clr_flags      (clr_flags)
);

// File: tb/test_sysctl_regfile.sv
`timescale 1ns/1ps
// Scoreboard bench: both build modes see the same stimulus; the driver queues
// expected outputs, the monitor compares them one cycle later.
module test_sysctl_regfile;

    typedef struct packed {
        logic [31:0] rd;
        logic v, il, fa, ft, fc, cf;
    } obs_t;

    typedef struct {
        obs_t  ea;
        obs_t  eb;
        string req;
        int    due;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [31:0] insn = '0, wdata = '0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0] rd_a, rd_b;
    logic v_a, il_a, fa_a, ft_a, fc_a, cf_a;
    logic v_b, il_b, fa_b, ft_b, fc_b, cf_b;

    int checks = 0, fails = 0, pcnt = 0;
    bit done = 0;
    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) pcnt <= pcnt + 1;

    sysctl_regfile #(.PU_MODE(0)) i_sysctl_regfile (
        .clk(clk), .rst_n(rst_n), .insn(insn), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rd_a), .rd_valid(v_a), .illegal(il_a), .tlb_flush_all(fa_a),
        .tlb_flush_asid(ft_a), .tc_flush(fc_a), .clr_flags(cf_a));

    sysctl_regfile #(.PU_MODE(1)) i_sysctl_regfile_pu (
        .clk(clk), .rst_n(rst_n), .insn(insn), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rd_b), .rd_valid(v_b), .illegal(il_b), .tlb_flush_all(fa_b),
        .tlb_flush_asid(ft_b), .tc_flush(fc_b), .clr_flags(cf_b));

    function automatic obs_t obs_a();
        return '{rd_a, v_a, il_a, fa_a, ft_a, fc_a, cf_a};
    endfunction
    function automatic obs_t obs_b();
        return '{rd_b, v_b, il_b, fa_b, ft_b, fc_b, cf_b};
    endfunction

    localparam obs_t Z   = '0;
    localparam obs_t ILL = '{32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam obs_t FA  = '{32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam obs_t FT  = '{32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam obs_t FC  = '{32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam obs_t CF  = '{32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    function automatic obs_t RD(input logic [31:0] x);
        return '{x, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    endfunction

    // Encode major/op2/minor into an instruction word (R1 positions).
    function automatic logic [31:0] mk(input int maj, input int o2, input int mn);
        return (32'(maj) << 16) | (32'(o2) << 5) | 32'(mn);
    endfunction

    task automatic check(input obs_t act, input obs_t exp, input string unit, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s unit=%s actual=%h expected=%h", req, unit, act, exp);
        end
    endtask

    // Driver: apply one access and queue the expected outputs of both units.
    task automatic acc(input logic rd, input logic wr, input logic [31:0] ins,
                       input logic [31:0] wd, input obs_t ea, input obs_t eb, input string req);
        @(negedge clk);
        rd_en = rd; wr_en = wr; insn = ins; wdata = wd;
        sb.push_back('{ea, eb, req, pcnt + 1});
    endtask

    // Monitor: compare queued expectations in their due cycle.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == pcnt) begin
            item_t it;
            it = sb.pop_front();
            check(obs_a(), it.ea, "std", it.req);
            check(obs_b(), it.eb, "pu", it.req);
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(obs_a(), Z, "std", "R12 reset outputs");
        check(obs_b(), Z, "pu", "R12 reset outputs");

        acc(1, 0, mk(13, 0, 0), 0, RD(0), RD(0), "R12 pid cleared");
        acc(0, 1, mk(13, 0, 0), 32'h12, FA, FA, "R2 pid change");
        acc(0, 1, mk(13, 0, 0), 32'h12, Z, Z, "R2 pid same");
        acc(1, 0, mk(13, 0, 0), 0, RD(32'h12), RD(32'h12), "R2 pid read");

        acc(0, 1, mk(13, 1, 0), 32'h5, FT, Z, "R3 ctx change");
        acc(0, 1, mk(13, 1, 0), 32'h5, Z, Z, "R3 ctx same");
        acc(1, 0, mk(13, 1, 0), 0, RD(5), RD(5), "R3 ctx read");

        acc(0, 1, mk(13, 2, 0), 32'hA, Z, Z, "R4 thr0 write");
        acc(0, 1, mk(13, 3, 0), 32'hB, Z, Z, "R4 thr1 write");
        acc(0, 1, mk(13, 4, 0), 32'hC, Z, Z, "R4 thr2 write");
        acc(1, 0, mk(13, 3, 0), 0, RD(32'hB), RD(32'hB), "R4 thr1 read");
        acc(0, 1, mk(13, 5, 0), 32'hFF, ILL, ILL, "R4 op2 5 illegal");
        acc(0, 1, mk(14, 2, 0), 32'h99, ILL, ILL, "R9 reserved write");
        acc(1, 0, mk(13, 2, 0), 0, RD(32'hA), RD(32'hA), "R9 no effect");
        acc(1, 0, mk(13, 4, 0), 0, RD(32'hC), RD(32'hC), "R4 thr2 read");

        acc(0, 1, mk(2, 2, 0), 32'h0000_0100, Z, Z, "R5 mask write");
        acc(1, 0, mk(2, 2, 0), 0, RD(24), RD(24), "R5 bit8");
        acc(0, 1, mk(2, 2, 0), 32'h0000_0001, Z, Z, "R5 mask write");
        acc(1, 0, mk(2, 2, 0), 0, RD(32), RD(32), "R5 bit0");
        acc(0, 1, mk(2, 2, 0), 32'h8000_0000, Z, Z, "R5 mask write");
        acc(1, 0, mk(2, 2, 0), 0, RD(1), RD(1), "R5 bit31");
        acc(0, 1, mk(2, 2, 0), 32'h0000_0C00, Z, Z, "R5 mask write");
        acc(1, 0, mk(2, 2, 0), 0, RD(22), RD(22), "R5 bit10");
        acc(0, 1, mk(2, 2, 0), 32'h0, Z, Z, "R5 mask write");
        acc(1, 0, mk(2, 2, 0), 0, RD(0), RD(0), "R5 zero mask");

        acc(0, 1, mk(2, 0, 0), 32'hDEAD_BEEF, Z, Z, "R6 base0 write");
        acc(0, 1, mk(2, 1, 0), 32'h1234_5678, Z, Z, "R6 base1 write");
        acc(1, 0, mk(2, 0, 0), 0, RD(32'hDEAD_BEEF), RD(32'hDEAD_BEEF), "R6 base0 read");
        acc(1, 0, mk(2, 1, 0), 0, RD(32'h1234_5678), RD(32'h1234_5678), "R6 base1 read");
        acc(1, 0, mk(2, 3, 0), 0, ILL, ILL, "R6 op2 3 illegal");

        acc(0, 1, mk(6, 0, 3), 32'h77, ILL, Z, "R7 region write");
        acc(1, 0, mk(6, 0, 3), 0, ILL, RD(32'h77), "R7 region read");
        acc(1, 0, mk(6, 0, 0), 0, ILL, RD(0), "R7 region0 read");
        acc(0, 1, mk(6, 0, 8), 32'h1, ILL, ILL, "R7 minor 8 illegal");

        acc(0, 1, mk(15, 0, 1), 32'hFFFF_FFFF, FC, FC, "R8 acc change");
        acc(1, 0, mk(15, 0, 1), 0, RD(32'h3FFF), RD(32'h3FFF), "R8 acc 14 bits");
        acc(0, 1, mk(15, 0, 1), 32'hC000_3FFF, Z, Z, "R8 acc upper ignored");
        acc(0, 1, mk(15, 0, 1), 32'h0000_1000, FC, FC, "R8 acc change");
        acc(1, 0, mk(15, 0, 1), 0, RD(32'h1000), RD(32'h1000), "R8 acc read");
        acc(1, 0, mk(15, 0, 2), 0, ILL, ILL, "R8 minor 2 illegal");
        acc(1, 0, mk(15, 1, 1), 0, ILL, ILL, "R8 op2 1 illegal");

        acc(1, 0, mk(4, 0, 0), 0, ILL, ILL, "R9 major 4");
        acc(0, 1, mk(12, 0, 0), 32'h5, ILL, ILL, "R9 major 12");
        acc(1, 0, mk(14, 0, 0), 0, ILL, ILL, "R9 major 14");
        acc(1, 0, mk(0, 0, 0), 0, ILL, ILL, "R9 major 0");
        acc(1, 0, mk(8, 0, 0), 0, ILL, ILL, "R9 major 8");

        acc(1, 0, mk(7, 0, 5), 0, CF, CF, "R10 cache read");
        acc(0, 1, mk(7, 0, 5), 32'hFFFF_FFFF, Z, Z, "R10 cache write");

        acc(1, 1, mk(13, 0, 0), 32'h34, FA, FA, "R11 write priority");
        acc(0, 0, 0, 0, Z, Z, "R12 idle");
        acc(1, 0, mk(13, 0, 0) | 32'hFFF0_FF10, 0, RD(32'h34), RD(32'h34), "R1 junk bits");
        acc(1, 0, mk(13, 0, 0) | (32'd7 << 21), 0, RD(32'h34), RD(32'h34), "R1 op1 ignored");
        acc(0, 0, 0, 0, Z, Z, "R12 idle");
        acc(0, 0, 0, 0, Z, Z, "R12 idle");

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule